// File: doc/BRIEF.md
# Address-Masked GPIO Controller

An eight-pin general-purpose I/O block reached over an APB slave port. Each pin has its own bit in every configuration register: output direction, output data, interrupt sense mode, both-edge selection, event polarity, interrupt enable, and a selector that hands the pin to an alternate on-chip function. The block drives pad outputs and output enables, samples pad inputs through a two-flop synchronizer, and raises a single interrupt line.

The data register sits behind a 256-word address window. Word-address bits [9:2] of each data access act as a per-bit mask. A write changes only the pins whose mask bit is set, and a read returns zero for every unmasked pin. Software can therefore set or sample any subset of pins in one bus transfer, with no read-modify-write sequence.

Top module: `gpio_mask_apb`

## Requirements
- R1: After reset, every register reads 0, pinOe is 0, intOut is 0, and a full-mask data read with all pins low returns 0.
- R2: A read at byte offset 0x000–0x3FC returns, for each pin n, the pin value ANDed with paddr[n+2]. The pin value is the driven output for a pin whose output enable is 1, and the synchronized input otherwise.
- R3: A write in the data window updates data bit n to pwdata[n] only when paddr[n+2] is 1. The other data bits keep their value.
- R4: Direction register (0x400): bit value 1 drives pinOe[n] high and puts data bit n on pinOut[n] while the pin is under software control.
- R5: Mode register (0x420): bit value 1 routes altOut[n] to pinOut[n] and altOe[n] to pinOe[n].
- R6: With sense bit 0 (0x404) and both-edge bit 0 (0x408), event bit 1 (0x40C) latches a status bit on a rising edge and event bit 0 latches it on a falling edge. The status bit stays set after the pin returns to its old level.
- R7: Both-edge bit 1 latches status on either edge, whatever the event bit holds.
- R8: Sense bit 1 makes status follow the synchronized pin: high-level when event is 1, low-level when event is 0. The bit is never sticky.
- R9: Writing 1 to bit n at 0x41C clears an edge-latched status bit n. Writes to that offset do not affect level-mode bits, and reads of it return 0.
- R10: Raw status (0x414) shows every bit regardless of enable. Masked status (0x418) is raw AND enable (0x410), and intOut is the OR of the masked bits.
- R11: Configuration registers read back the value last written. Unmapped offsets at or above 0x424 read 0.
- R12: Transfers complete with no wait states: pready is 1 and pslverr is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write |
| paddr | input | 12 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | APB ready, always 1 |
| pslverr | output | 1 | APB error, always 0 |
| pinIn | input | 8 | Pad input levels |
| pinOut | output | 8 | Pad output levels |
| pinOe | output | 8 | Pad output enables |
| altOut | input | 8 | Alternate-function output data |
| altOe | input | 8 | Alternate-function output enables |
| intOut | output | 1 | Combined interrupt |

## Verification
The assertions assume well-formed APB transfers: one setup cycle followed by one access cycle, with the address and write data held stable across both. The bench's transfer tasks produce only that shape. The assertions also assume that pad inputs may change at any time, because the synchronizer absorbs them. The bench changes pinIn only on falling clock edges and then waits at least four cycles before it samples any status that depends on the change.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;
  localparam int unsigned GPIO_PINS = 8;

  typedef enum logic [3:0] {
    RD_NONE, RD_DATA, RD_DIR, RD_SENSE, RD_BOTH,
    RD_EVENT, RD_IE, RD_RAW, RD_MASKED, RD_MODE
  } rd_sel_e;

  typedef struct packed {
    logic wrData;
    logic wrDir;
    logic wrSense;
    logic wrBoth;
    logic wrEvent;
    logic wrIe;
    logic wrClr;
    logic wrMode;
    rd_sel_e rdSel;
    logic [GPIO_PINS-1:0] mask;
  } gpio_stb_t;
endpackage

// File: rtl/gpio_apb_ctrl.sv
module gpio_apb_ctrl
  import gpio_mask_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned PINS   = GPIO_PINS
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output gpio_stb_t         stb
);
  localparam int unsigned WORD_W = ADDR_W - 2;
  localparam logic [WORD_W-1:0] CFG_BASE = WORD_W'(1) << PINS;
  localparam logic [WORD_W-1:0] SLOT_DIR    = 'd0;
  localparam logic [WORD_W-1:0] SLOT_SENSE  = 'd1;
  localparam logic [WORD_W-1:0] SLOT_BOTH   = 'd2;
  localparam logic [WORD_W-1:0] SLOT_EVENT  = 'd3;
  localparam logic [WORD_W-1:0] SLOT_IE     = 'd4;
  localparam logic [WORD_W-1:0] SLOT_RAW    = 'd5;
  localparam logic [WORD_W-1:0] SLOT_MASKED = 'd6;
  localparam logic [WORD_W-1:0] SLOT_CLR    = 'd7;
  localparam logic [WORD_W-1:0] SLOT_MODE   = 'd8;

  logic [WORD_W-1:0] wordIdx;
  logic [WORD_W-1:0] cfgIdx;
  logic inWindow;
  logic wrAcc;
  logic rdAcc;
  logic unusedLowAddr;

  assign wordIdx  = paddr[ADDR_W-1:2];
  assign cfgIdx   = wordIdx - CFG_BASE;
  assign inWindow = (wordIdx >> PINS) == '0;
  assign wrAcc    = psel & penable & pwrite;
  assign rdAcc    = psel & penable & ~pwrite;
  assign unusedLowAddr = ^paddr[1:0];

  always_comb begin
    stb       = '0;
    stb.rdSel = RD_NONE;
    stb.mask  = paddr[PINS+1:2];
    if (inWindow) begin
      stb.wrData = wrAcc;
      if (rdAcc) stb.rdSel = RD_DATA;
    end else begin
      case (cfgIdx)
        SLOT_DIR: begin
          stb.wrDir = wrAcc;
          if (rdAcc) stb.rdSel = RD_DIR;
        end
        SLOT_SENSE: begin
          stb.wrSense = wrAcc;
          if (rdAcc) stb.rdSel = RD_SENSE;
        end
        SLOT_BOTH: begin
          stb.wrBoth = wrAcc;
          if (rdAcc) stb.rdSel = RD_BOTH;
        end
        SLOT_EVENT: begin
          stb.wrEvent = wrAcc;
          if (rdAcc) stb.rdSel = RD_EVENT;
        end
        SLOT_IE: begin
          stb.wrIe = wrAcc;
          if (rdAcc) stb.rdSel = RD_IE;
        end
        SLOT_RAW: begin
          if (rdAcc) stb.rdSel = RD_RAW;
        end
        SLOT_MASKED: begin
          if (rdAcc) stb.rdSel = RD_MASKED;
        end
        SLOT_CLR: begin
          stb.wrClr = wrAcc;
        end
        SLOT_MODE: begin
          stb.wrMode = wrAcc;
          if (rdAcc) stb.rdSel = RD_MODE;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned PINS = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [PINS-1:0] syncIn,
  input  logic [PINS-1:0] senseReg,
  input  logic [PINS-1:0] bothReg,
  input  logic [PINS-1:0] eventReg,
  input  logic [PINS-1:0] clrMask,
  output logic [PINS-1:0] rawStat
);
  logic [PINS-1:0] prevIn;
  logic [PINS-1:0] nextRaw;

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    logic rise;
    logic fall;
    logic edgeHit;
    logic levelHit;
    assign rise     = syncIn[i] & ~prevIn[i];
    assign fall     = ~syncIn[i] & prevIn[i];
    assign edgeHit  = bothReg[i] ? (rise | fall) : (eventReg[i] ? rise : fall);
    assign levelHit = eventReg[i] ? syncIn[i] : ~syncIn[i];
    assign nextRaw[i] = senseReg[i] ? levelHit
                                    : (edgeHit | (rawStat[i] & ~clrMask[i]));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevIn  <= '0;
      rawStat <= '0;
    end else begin
      prevIn  <= syncIn;
      rawStat <= nextRaw;
    end
  end
endmodule

// File: rtl/gpio_datapath.sv
module gpio_datapath
  import gpio_mask_pkg::*;
#(
  parameter int unsigned PINS = GPIO_PINS
) (
  input  logic            clk,
  input  logic            rstN,
  input  gpio_stb_t       stb,
  input  logic [PINS-1:0] wrBus,
  input  logic [PINS-1:0] syncIn,
  input  logic [PINS-1:0] rawStat,
  input  logic [PINS-1:0] altOut,
  input  logic [PINS-1:0] altOe,
  output logic [PINS-1:0] dataReg,
  output logic [PINS-1:0] dirReg,
  output logic [PINS-1:0] senseReg,
  output logic [PINS-1:0] bothReg,
  output logic [PINS-1:0] eventReg,
  output logic [PINS-1:0] ieReg,
  output logic [PINS-1:0] modeReg,
  output logic [PINS-1:0] clrMask,
  output logic [PINS-1:0] pinOut,
  output logic [PINS-1:0] pinOe,
  output logic [PINS-1:0] rdVal,
  output logic            intOut
);
  logic [PINS-1:0] pinVal;
  logic [PINS-1:0] maskedStat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg  <= '0;
      dirReg   <= '0;
      senseReg <= '0;
      bothReg  <= '0;
      eventReg <= '0;
      ieReg    <= '0;
      modeReg  <= '0;
    end else begin
      if (stb.wrData)  dataReg  <= (dataReg & ~stb.mask) | (wrBus & stb.mask);
      if (stb.wrDir)   dirReg   <= wrBus;
      if (stb.wrSense) senseReg <= wrBus;
      if (stb.wrBoth)  bothReg  <= wrBus;
      if (stb.wrEvent) eventReg <= wrBus;
      if (stb.wrIe)    ieReg    <= wrBus;
      if (stb.wrMode)  modeReg  <= wrBus;
    end
  end

  assign clrMask = stb.wrClr ? wrBus : '0;

  for (genvar i = 0; i < PINS; i++) begin : g_route
    assign pinOut[i] = modeReg[i] ? altOut[i] : dataReg[i];
    assign pinOe[i]  = modeReg[i] ? altOe[i]  : dirReg[i];
    assign pinVal[i] = pinOe[i] ? pinOut[i] : syncIn[i];
  end

  assign maskedStat = rawStat & ieReg;
  assign intOut     = |maskedStat;

  always_comb begin
    case (stb.rdSel)
      RD_DATA:   rdVal = pinVal & stb.mask;
      RD_DIR:    rdVal = dirReg;
      RD_SENSE:  rdVal = senseReg;
      RD_BOTH:   rdVal = bothReg;
      RD_EVENT:  rdVal = eventReg;
      RD_IE:     rdVal = ieReg;
      RD_RAW:    rdVal = rawStat;
      RD_MASKED: rdVal = maskedStat;
      RD_MODE:   rdVal = modeReg;
      default:   rdVal = '0;
    endcase
  end
endmodule

// File: rtl/gpio_mask_apb.sv
module gpio_mask_apb
  import gpio_mask_pkg::*;
#(
  parameter int unsigned PINS   = GPIO_PINS,
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  input  logic [PINS-1:0]   pinIn,
  output logic [PINS-1:0]   pinOut,
  output logic [PINS-1:0]   pinOe,
  input  logic [PINS-1:0]   altOut,
  input  logic [PINS-1:0]   altOe,
  output logic              intOut
);
  gpio_stb_t       stb;
  logic [PINS-1:0] wrBus;
  logic [PINS-1:0] syncIn;
  logic [PINS-1:0] rawStat;
  logic [PINS-1:0] dataReg, dirReg, senseReg, bothReg, eventReg, ieReg, modeReg;
  logic [PINS-1:0] clrMask;
  logic [PINS-1:0] rdVal;
  logic            unusedHighData;

  assign wrBus          = pwdata[PINS-1:0];
  assign unusedHighData = ^pwdata[DATA_W-1:PINS];
  assign prdata         = DATA_W'(rdVal);
  assign pready         = 1'b1;
  assign pslverr        = 1'b0;

  gpio_apb_ctrl #(.ADDR_W(ADDR_W), .PINS(PINS)) u_ctrl (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr), .stb(stb)
  );

  gpio_sync2 #(.W(PINS)) u_sync (
    .clk(clk), .rstN(rstN), .d(pinIn), .q(syncIn)
  );

  gpio_irq_detect #(.PINS(PINS)) u_irq (
    .clk(clk), .rstN(rstN), .syncIn(syncIn), .senseReg(senseReg),
    .bothReg(bothReg), .eventReg(eventReg), .clrMask(clrMask), .rawStat(rawStat)
  );

  gpio_datapath #(.PINS(PINS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrBus(wrBus), .syncIn(syncIn),
    .rawStat(rawStat), .altOut(altOut), .altOe(altOe),
    .dataReg(dataReg), .dirReg(dirReg), .senseReg(senseReg), .bothReg(bothReg),
    .eventReg(eventReg), .ieReg(ieReg), .modeReg(modeReg), .clrMask(clrMask),
    .pinOut(pinOut), .pinOe(pinOe), .rdVal(rdVal), .intOut(intOut)
  );
endmodule

// File: rtl/gpio_mask_apb_checker.sv
module gpio_mask_apb_checker
  import gpio_mask_pkg::*;
#(
  parameter int unsigned PINS = GPIO_PINS
) (
  input logic            clk,
  input logic            rstN,
  input gpio_stb_t       stb,
  input logic [PINS-1:0] wrBus,
  input logic [PINS-1:0] syncIn,
  input logic [PINS-1:0] dataReg,
  input logic [PINS-1:0] dirReg,
  input logic [PINS-1:0] senseReg,
  input logic [PINS-1:0] eventReg,
  input logic [PINS-1:0] ieReg,
  input logic [PINS-1:0] rawStat,
  input logic [PINS-1:0] clrMask,
  input logic            intOut
);
  // R3: unmasked data bits hold across a window write
  a_r3_unmasked_hold: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrData |=> ((dataReg & ~$past(stb.mask)) == ($past(dataReg) & ~$past(stb.mask))));

  // R3: masked data bits take the written value
  a_r3_masked_take: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrData |=> ((dataReg & $past(stb.mask)) == ($past(wrBus) & $past(stb.mask))));

  // R4: direction only changes through its own write strobe
  a_r4_dir_stable: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrDir |=> $stable(dirReg));

  // R6: an edge-latched bit stays set unless cleared
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(rawStat) & ~$past(senseReg) & ~$past(clrMask)) & ~rawStat) == '0));

  // R8: level-mode bits follow the synchronized pin one cycle later
  a_r8_level_follow: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((rawStat & $past(senseReg)) ==
              ($past(senseReg) & (($past(eventReg) & $past(syncIn)) |
                                  (~$past(eventReg) & ~$past(syncIn))))));

  // R10: interrupt needs at least one enabled bit
  a_r10_int_needs_enable: assert property (@(posedge clk) disable iff (!rstN)
    intOut |-> (ieReg != '0));
endmodule

bind gpio_mask_apb gpio_mask_apb_checker #(.PINS(PINS)) u_chk (
  .clk(clk), .rstN(rstN), .stb(stb), .wrBus(wrBus), .syncIn(syncIn),
  .dataReg(dataReg), .dirReg(dirReg), .senseReg(senseReg), .eventReg(eventReg),
  .ieReg(ieReg), .rawStat(rawStat), .clrMask(clrMask), .intOut(intOut)
);

// File: tb/gpio_mask_apb_test.sv
`timescale 1ns/1ps
module gpio_mask_apb_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [7:0]  pinIn = '0, pinOut, pinOe, altOut = '0, altOe = '0;
  logic        intOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  gpio_mask_apb uut (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe),
    .altOut(altOut), .altOe(altOe), .intOut(intOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apbWrite(input logic [11:0] a, input logic [7:0] d);
    psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = {24'hABCDEF, d}; penable = 1'b0;
    @(negedge clk) penable = 1'b1;
    @(negedge clk) begin psel = 1'b0; penable = 1'b0; pwrite = 1'b0; end
  endtask

  task automatic apbRead(input logic [11:0] a, output logic [31:0] d);
    psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
    @(negedge clk) penable = 1'b1;
    #1 d = prdata;
    @(negedge clk) begin psel = 1'b0; penable = 1'b0; end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  localparam logic [11:0] A_DIR = 12'h400, A_SENSE = 12'h404, A_BOTH = 12'h408,
    A_EVENT = 12'h40C, A_IE = 12'h410, A_RAW = 12'h414, A_MASKED = 12'h418,
    A_CLR = 12'h41C, A_MODE = 12'h420, A_FULL = 12'h3FC;

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [7:0]  cur;
    logic [7:0]  v;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);

    // R1 reset state, R12 handshake
    chk("R1 pinOe", pinOe, 0);
    chk("R1 intOut", intOut, 0);
    chk("R12 pready", pready, 1);
    chk("R12 pslverr", pslverr, 0);
    apbRead(A_DIR, rd);  chk("R1 dir", rd, 0);
    apbRead(A_RAW, rd);  chk("R1 raw", rd, 0);
    apbRead(A_FULL, rd); chk("R1 data", rd, 0);

    // R11 readback
    apbWrite(A_DIR, 8'h5A);   apbRead(A_DIR, rd);   chk("R11 dir", rd, 32'h5A);
    apbWrite(A_BOTH, 8'h81);  apbRead(A_BOTH, rd);  chk("R11 both", rd, 32'h81);
    apbWrite(A_EVENT, 8'hE7); apbRead(A_EVENT, rd); chk("R11 event", rd, 32'hE7);
    apbWrite(A_SENSE, 8'h3C); apbRead(A_SENSE, rd); chk("R11 sense", rd, 32'h3C);
    apbWrite(A_IE, 8'h18);    apbRead(A_IE, rd);    chk("R11 ie", rd, 32'h18);
    apbWrite(A_MODE, 8'h66);  apbRead(A_MODE, rd);  chk("R11 mode", rd, 32'h66);
    apbRead(12'h424, rd); chk("R11 unmapped", rd, 0);
    apbRead(12'h7FC, rd); chk("R11 unmapped top", rd, 0);
    apbRead(A_CLR, rd);   chk("R9 clear reads zero", rd, 0);
    apbWrite(A_SENSE, 8'h00); apbWrite(A_BOTH, 8'h00); apbWrite(A_EVENT, 8'h00);
    apbWrite(A_IE, 8'h00);    apbWrite(A_MODE, 8'h00);
    apbWrite(A_CLR, 8'hFF);
    apbRead(A_RAW, rd); chk("R9 all cleared", rd, 0);

    // R3 masked write sweep over every mask, R4 output drive
    apbWrite(A_DIR, 8'hFF);
    chk("R4 oe all", pinOe, 32'hFF);
    cur = 8'h00;
    for (int m = 0; m < 256; m++) begin
      v = 8'((m * 37 + 11) ^ 8'h5A);
      apbWrite(12'(m << 2), v);
      cur = (cur & ~8'(m)) | (v & 8'(m));
      chk("R3 pinOut", pinOut, cur);
      if ((m % 16) == 15) begin
        apbRead(A_FULL, rd);
        chk("R2 output readback", rd, cur);
      end
    end

    // R2 masked read sweep on inputs
    apbWrite(A_DIR, 8'h00);
    chk("R4 oe none", pinOe, 0);
    pinIn = 8'h6C;
    waitCyc(4);
    for (int m = 0; m < 256; m++) begin
      apbRead(12'(m << 2), rd);
      chk("R2 masked read", rd, 32'(8'h6C & 8'(m)));
    end
    apbWrite(A_DIR, 8'h0F);
    apbRead(A_FULL, rd);
    chk("R2 mixed dir", rd, 32'((cur & 8'h0F) | (8'h6C & 8'hF0)));
    chk("R4 mixed oe", pinOe, 32'h0F);
    chk("R4 mixed out", pinOut & 8'h0F, 32'(cur & 8'h0F));

    // R5 alternate function routing
    apbWrite(12'h3FC, 8'hAA); cur = 8'hAA;
    apbWrite(A_DIR, 8'hF0);
    altOut = 8'h03; altOe = 8'h05;
    apbWrite(A_MODE, 8'h0F);
    chk("R5 pinOut", pinOut, 32'hA3);
    chk("R5 pinOe", pinOe, 32'hF5);
    altOut = 8'h0C; altOe = 8'h0A;
    #1;
    chk("R5 pinOut follows alt", pinOut, 32'hAC);
    chk("R5 pinOe follows alt", pinOe, 32'hFA);
    apbWrite(A_MODE, 8'h00);
    apbWrite(A_DIR, 8'h00);
    chk("R5 released", pinOe, 0);

    // Interrupts
    pinIn = 8'h00;
    waitCyc(4);
    apbWrite(A_CLR, 8'hFF);
    apbRead(A_RAW, rd); chk("R9 baseline", rd, 0);

    // R6 single-edge detection
    apbWrite(A_EVENT, 8'h01);
    apbWrite(A_IE, 8'h03);
    pinIn = 8'h01; waitCyc(4);
    apbRead(A_RAW, rd); chk("R6 rising latched", rd & 32'h03, 32'h01);
    chk("R10 int on rising", intOut, 1);
    pinIn = 8'h00; waitCyc(4);
    apbRead(A_RAW, rd); chk("R6 sticky after fall", rd & 32'h03, 32'h01);
    pinIn = 8'h02; waitCyc(4);
    apbRead(A_RAW, rd); chk("R6 rise ignored on falling pin", rd & 32'h02, 0);
    pinIn = 8'h00; waitCyc(4);
    apbRead(A_RAW, rd); chk("R6 falling latched", rd & 32'h03, 32'h03);
    apbRead(A_MASKED, rd); chk("R10 masked", rd, 32'h03);
    apbWrite(A_CLR, 8'h01);
    apbRead(A_RAW, rd); chk("R9 partial clear", rd & 32'h03, 32'h02);
    chk("R10 int still up", intOut, 1);
    apbWrite(A_CLR, 8'h02);
    chk("R9 int cleared", intOut, 0);

    // R7 both edges on pin 2
    apbWrite(A_BOTH, 8'h04);
    apbWrite(A_IE, 8'h04);
    pinIn = 8'h04; waitCyc(4);
    apbRead(A_RAW, rd); chk("R7 rise", rd & 32'h04, 32'h04);
    apbWrite(A_CLR, 8'h04);
    apbRead(A_RAW, rd); chk("R9 both cleared", rd & 32'h04, 0);
    pinIn = 8'h00; waitCyc(4);
    apbRead(A_RAW, rd); chk("R7 fall", rd & 32'h04, 32'h04);
    apbWrite(A_CLR, 8'h04);
    apbWrite(A_BOTH, 8'h00);

    // R8 level sensitivity on pin 3
    apbWrite(A_EVENT, 8'h08);
    apbWrite(A_SENSE, 8'h08);
    apbWrite(A_IE, 8'h08);
    apbRead(A_RAW, rd); chk("R8 high-level idle", rd & 32'h08, 0);
    pinIn = 8'h08; waitCyc(4);
    apbRead(A_RAW, rd); chk("R8 high-level set", rd & 32'h08, 32'h08);
    chk("R10 level int", intOut, 1);
    apbWrite(A_CLR, 8'h08);
    apbRead(A_RAW, rd); chk("R9 clear ignored on level", rd & 32'h08, 32'h08);
    pinIn = 8'h00; waitCyc(4);
    apbRead(A_RAW, rd); chk("R8 not sticky", rd & 32'h08, 0);
    chk("R8 int drops", intOut, 0);
    apbWrite(A_EVENT, 8'h00);
    apbRead(A_RAW, rd); chk("R8 low-level set", rd & 32'h08, 32'h08);

    // R10 enable gating
    apbWrite(A_IE, 8'h00);
    chk("R10 disabled int", intOut, 0);
    apbRead(A_MASKED, rd); chk("R10 masked zero", rd, 0);
    apbRead(A_RAW, rd); chk("R10 raw visible", rd & 32'h08, 32'h08);
    apbWrite(A_IE, 8'h08);
    chk("R10 enabled int", intOut, 1);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule